// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block steers the calibration of a measurement converter. A software-visible request line, two select bits and a range input come in. A clean request pulse launches one timed calibration step. During the step a busy output stays high, and a three-bit source strobe picks the front-end input: ground, the reference, or the analog input. At two fixed internal points the block copies the already-filtered measurement word into a zero-scale register and a full-scale register. Both registers are exposed at the ports.

Four step kinds exist. A self step measures ground and then the reference. An offset-versus-reference step measures the input and then the reference. A two-part system calibration first captures zero-scale from the input, then full-scale from the input. Each kind runs for its own fixed number of master clocks. The gain half of the two-part calibration is only legal after its zero half has completed. A validity flag tells downstream arithmetic whether the stored pair may be trusted. The flag drops whenever the range input moves. The filter and the slope arithmetic live outside this block.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, cal_busy, src_sel, zero_word, full_word, seq_err and cal_valid are all zero.
- R2: cal_req passes through two synchronizer flops. A request is taken only if its synchronized level stayed high for at least MIN_HIGH (4) consecutive clocks. When the request is taken, cal_busy rises on the third rising clock edge after cal_req falls. A shorter pulse is ignored.
- R3: cal_sel is sampled when the request is taken. The codes are: 00 self step (ground then reference), 10 offset-versus-reference (input then reference), 11 system zero step (input only), 01 system gain step (input only). src_sel is bit0 ground, bit1 reference, bit2 analog input. Two-part steps show their first source while the step count is below half the step length, and their second source from then on.
- R4: cal_busy stays high for exactly L clocks. L is the base length divided (integer division) by LEN_DIV. The base lengths are 3145655 for self, 1052599 for zero, 1068813 for gain and 2117389 for offset-versus-reference.
- R5: Two-part steps capture zero_word from meas_word in step cycle L/2-1 (counting from 0) and full_word in cycle L-1. A zero step captures only zero_word, in cycle L-1. A gain step captures only full_word, in cycle L-1. Neither register changes at any other time.
- R6: A request whose synchronized level is high at any time during a step is ignored, even if it falls after the step ends.
- R7: A gain step taken before any completed zero step does not run. Instead, seq_err rises on the edge where the step would have started, and full_word keeps its value. seq_err clears when the next step starts.
- R8: After a completed zero step and gain step, a repeated zero step changes zero_word only and keeps full_word.
- R9: cal_valid clears when a step starts, and on any clock where bipolar differs from its value one clock earlier. That clear wins over a completion on the same clock. On completion, cal_valid sets for self, offset-versus-reference and gain steps. For a zero step it sets only if a full-scale value was captured earlier.
- R10: src_sel is zero while idle and has exactly one bit set while cal_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low reset |
| cal_req | input | 1 | asynchronous calibration request |
| cal_sel | input | 2 | step kind, sampled when the request is taken |
| bipolar | input | 1 | range select, not latched |
| meas_word | input | DATA_W | filtered measurement word |
| cal_busy | output | 1 | high for the whole step |
| src_sel | output | 3 | one-hot source strobe: ground, reference, input |
| zero_word | output | DATA_W | stored zero-scale word |
| full_word | output | DATA_W | stored full-scale word |
| seq_err | output | 1 | gain step refused for lack of zero step |
| cal_valid | output | 1 | stored pair is trustworthy |

## Verification
Two things can land on the same clock: a step completing, which would set the validity flag, and a range change, which must clear it. The bench counts busy cycles from the first busy sample and flips bipolar in the sampled cycle of the final step count. That makes the change and the completion meet on one edge. The per-clock reference model and a directed check both expect cal_valid to stay low after that edge, while the step's captures still take place.

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int DATA_W   = 20,
  parameter int LEN_DIV  = 1,
  parameter int MIN_HIGH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req,
  input  logic [1:0]        cal_sel,
  input  logic              bipolar,
  input  logic [DATA_W-1:0] meas_word,
  output logic              cal_busy,
  output logic [2:0]        src_sel,
  output logic [DATA_W-1:0] zero_word,
  output logic [DATA_W-1:0] full_word,
  output logic              seq_err,
  output logic              cal_valid
);
  localparam int unsigned L_SELF = 3145655 / LEN_DIV;
  localparam int unsigned L_ZERO = 1052599 / LEN_DIV;
  localparam int unsigned L_GAIN = 1068813 / LEN_DIV;
  localparam int unsigned L_OFFS = 2117389 / LEN_DIV;
  localparam int CW = $clog2(L_SELF + 1);
  localparam int HW = $clog2(MIN_HIGH + 1);

  localparam logic [1:0] M_SELF = 2'b00;
  localparam logic [1:0] M_GAIN = 2'b01;
  localparam logic [1:0] M_OFFS = 2'b10;
  localparam logic [1:0] M_ZERO = 2'b11;

  localparam logic [2:0] SRC_GND = 3'b001;
  localparam logic [2:0] SRC_REF = 3'b010;
  localparam logic [2:0] SRC_AIN = 3'b100;

  logic          req_m, req_s, req_q, stale;
  logic [HW-1:0] hi_cnt;
  logic [1:0]    mode;
  logic [CW-1:0] cnt, len, half;
  logic          off_ok, full_ok, bip_q;

  function automatic logic [CW-1:0] len_of(input logic [1:0] s);
    case (s)
      M_SELF:  len_of = CW'(L_SELF);
      M_GAIN:  len_of = CW'(L_GAIN);
      M_OFFS:  len_of = CW'(L_OFFS);
      default: len_of = CW'(L_ZERO);
    endcase
  endfunction

  wire req_fall = req_q & ~req_s;
  wire accept   = req_fall & ~cal_busy & (hi_cnt >= HW'(MIN_HIGH));
  wire gain_bad = accept & (cal_sel == M_GAIN) & ~off_ok;
  wire start    = accept & ~gain_bad;
  wire two_ph   = (mode == M_SELF) | (mode == M_OFFS);
  wire last     = cal_busy & (cnt == len - 1'b1);
  wire mid      = cal_busy & two_ph & (cnt == half - 1'b1);
  wire first_ph = cnt < half;
  wire bip_chg  = bipolar != bip_q;

  assign half = len >> 1;

  always_comb begin
    src_sel = 3'b000;
    if (cal_busy) begin
      case (mode)
        M_SELF:  src_sel = first_ph ? SRC_GND : SRC_REF;
        M_OFFS:  src_sel = first_ph ? SRC_AIN : SRC_REF;
        default: src_sel = SRC_AIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m  <= 1'b0;
      req_s  <= 1'b0;
      req_q  <= 1'b0;
      stale  <= 1'b0;
      hi_cnt <= '0;
    end else begin
      req_m <= cal_req;
      req_s <= req_m;
      req_q <= req_s;
      if (!req_s) begin
        hi_cnt <= '0;
        stale  <= 1'b0;
      end else if (cal_busy) begin
        stale <= 1'b1;
      end else if (!stale && hi_cnt < HW'(MIN_HIGH)) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_busy  <= 1'b0;
      mode      <= M_SELF;
      cnt       <= '0;
      len       <= '0;
      seq_err   <= 1'b0;
      zero_word <= '0;
      full_word <= '0;
      off_ok    <= 1'b0;
      full_ok   <= 1'b0;
      cal_valid <= 1'b0;
      bip_q     <= bipolar;
    end else begin
      bip_q <= bipolar;
      if (start) begin
        cal_busy <= 1'b1;
        cnt      <= '0;
        len      <= len_of(cal_sel);
        mode     <= cal_sel;
        seq_err  <= 1'b0;
      end else if (cal_busy) begin
        if (last) cal_busy <= 1'b0;
        else      cnt      <= cnt + 1'b1;
      end
      if (gain_bad) seq_err <= 1'b1;

      if (mid | (last & (mode == M_ZERO))) zero_word <= meas_word;
      if (last & (mode != M_ZERO))         full_word <= meas_word;
      if (last & (mode == M_ZERO))         off_ok    <= 1'b1;
      if (last & (mode != M_ZERO))         full_ok   <= 1'b1;

      if (bip_chg | start) cal_valid <= 1'b0;
      else if (last)       cal_valid <= (mode != M_ZERO) | full_ok;
    end
  end
endmodule

module cal_seq_chk #(
  parameter int DATA_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bipolar,
  input logic              cal_busy,
  input logic [2:0]        src_sel,
  input logic [DATA_W-1:0] zero_word,
  input logic [DATA_W-1:0] full_word,
  input logic              seq_err,
  input logic              cal_valid
);
  assert_src_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> ($countones(src_sel) == 1));
  assert_src_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |-> (src_sel == 3'b000));
  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cal_busy) |-> $stable(zero_word));
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cal_busy) |-> $stable(full_word));
  assert_err_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> (!cal_busy && $stable(full_word)));
  assert_valid_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_valid) |-> $fell(cal_busy));
  assert_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !cal_valid);
  assert_bip_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bipolar != $past(bipolar)) |=> !cal_valid);
endmodule

bind cal_sequencer cal_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .cal_busy(cal_busy),
  .src_sel(src_sel), .zero_word(zero_word), .full_word(full_word),
  .seq_err(seq_err), .cal_valid(cal_valid)
);

// File: tb/sim_cal_sequencer.sv
`timescale 1ns/1ps
module sim_cal_sequencer;
  localparam int DW  = 20;
  localparam int DIV = 4096;
  localparam int LS  = 3145655 / DIV;
  localparam int LZ  = 1052599 / DIV;
  localparam int LG  = 1068813 / DIV;
  localparam int LO  = 2117389 / DIV;

  logic clk = 1'b0, rst_n = 1'b0, cal_req = 1'b0, bipolar = 1'b0;
  logic [1:0] cal_sel = 2'b00;
  logic [DW-1:0] meas_word = '0;
  logic cal_busy, seq_err, cal_valid;
  logic [2:0] src_sel;
  logic [DW-1:0] zero_word, full_word;

  always #2 clk = ~clk;

  cal_sequencer #(.DATA_W(DW), .LEN_DIV(DIV), .MIN_HIGH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_sel(cal_sel),
    .bipolar(bipolar), .meas_word(meas_word), .cal_busy(cal_busy),
    .src_sel(src_sel), .zero_word(zero_word), .full_word(full_word),
    .seq_err(seq_err), .cal_valid(cal_valid));

  int checks = 0, failures = 0, cyc = 0;
  int starts = 0, run = 0, last_run = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_r1, m_rs, m_rq, m_hi, m_stale, m_busy, m_mode, m_cnt, m_len;
  int m_zero, m_full, m_err, m_valid, m_offok, m_fullok, m_bip;

  function automatic int len_for(input int s);
    case (s)
      0: return LS; 1: return LG; 2: return LO; default: return LZ;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_rs = 0; m_rq = 0; m_hi = 0; m_stale = 0; m_busy = 0;
      m_mode = 0; m_cnt = 0; m_len = 0; m_zero = 0; m_full = 0; m_err = 0;
      m_valid = 0; m_offok = 0; m_fullok = 0; m_bip = bipolar;
    end else begin
      automatic bit acc  = m_rq && !m_rs && !m_busy && m_hi >= 4;
      automatic bit bad  = acc && cal_sel == 2'b01 && !m_offok;
      automatic bit st   = acc && !bad;
      automatic bit fin  = m_busy && m_cnt == m_len - 1;
      automatic bit two  = m_mode == 0 || m_mode == 2;
      automatic bit mid  = m_busy && two && m_cnt == m_len / 2 - 1;
      if (!m_rs) begin m_hi = 0; m_stale = 0; end
      else if (m_busy) m_stale = 1;
      else if (!m_stale && m_hi < 4) m_hi++;
      if (mid || (fin && m_mode == 3)) m_zero = meas_word;
      if (fin && m_mode != 3) m_full = meas_word;
      if (bipolar != m_bip || st) m_valid = 0;
      else if (fin) m_valid = (m_mode != 3) || m_fullok;
      if (fin && m_mode == 3) m_offok = 1;
      if (fin && m_mode != 3) m_fullok = 1;
      if (st) begin
        m_busy = 1; m_cnt = 0; m_len = len_for(cal_sel); m_mode = cal_sel; m_err = 0;
      end else if (m_busy) begin
        if (fin) m_busy = 0; else m_cnt++;
      end
      if (bad) m_err = 1;
      m_rq = m_rs; m_rs = m_r1; m_r1 = cal_req; m_bip = bipolar;
    end
  end

  always @(negedge clk) begin
    cyc++;
    meas_word <= DW'(cyc * 40503 + 7);
    if (rst_n) begin
      automatic int es = 0;
      if (m_busy) begin
        if (m_mode == 0)      es = (m_cnt < m_len / 2) ? 1 : 2;
        else if (m_mode == 2) es = (m_cnt < m_len / 2) ? 4 : 2;
        else                  es = 4;
      end
      chk(cal_busy == m_busy, "R4 busy", cal_busy, m_busy);
      chk(src_sel == es, "R3 src_sel", src_sel, es);
      chk(zero_word == m_zero, "R5 zero_word", zero_word, m_zero);
      chk(full_word == m_full, "R5 full_word", full_word, m_full);
      chk(seq_err == m_err, "R7 seq_err", seq_err, m_err);
      chk(cal_valid == m_valid, "R9 cal_valid", cal_valid, m_valid);
      if (cal_busy) run++;
      else if (run != 0) begin last_run = run; run = 0; starts++; end
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_req(input logic [1:0] sel, input int hi);
    @(negedge clk);
    cal_sel = sel; cal_req = 1'b1;
    repeat (hi) @(negedge clk);
    cal_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (cal_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cal_busy == 0 && src_sel == 0 && seq_err == 0 && cal_valid == 0, "R1 reset outputs", {cal_busy, src_sel, seq_err, cal_valid}, 0);
    chk(zero_word == 0 && full_word == 0, "R1 reset registers", zero_word | full_word, 0);

    do_req(2'b00, 3); repeat (10) @(negedge clk);
    chk(starts == 0 && cal_busy == 0, "R2 short pulse ignored", starts, 0);

    do_req(2'b01, 6); repeat (3) @(negedge clk);
    chk(seq_err == 1, "R7 gain before zero flags error", seq_err, 1);
    chk(full_word == 0 && starts == 0 && cal_busy == 0, "R7 gain refused", full_word, 0);

    do_req(2'b00, 4); wait_idle();
    chk(last_run == LS, "R4 self length", last_run, LS);
    chk(seq_err == 0 && cal_valid == 1, "R9 valid after self", cal_valid, 1);

    do_req(2'b10, 5);
    repeat (100) @(negedge clk);
    cal_req = 1'b1;
    wait_idle(); repeat (20) @(negedge clk);
    cal_req = 1'b0; repeat (10) @(negedge clk);
    chk(starts == 2 && cal_busy == 0, "R6 request during step ignored", starts, 2);
    chk(last_run == LO, "R4 offset length", last_run, LO);

    do_req(2'b11, 4); wait_idle();
    chk(last_run == LZ, "R4 zero length", last_run, LZ);
    do_req(2'b01, 4); wait_idle();
    chk(last_run == LG && seq_err == 0, "R4 gain length", last_run, LG);
    chk(cal_valid == 1, "R9 valid after gain", cal_valid, 1);

    keep = full_word;
    do_req(2'b11, 4); wait_idle();
    chk(full_word == keep, "R8 repeated zero keeps full", full_word, keep);
    chk(cal_valid == 1, "R8 valid after repeated zero", cal_valid, 1);

    bipolar = ~bipolar; repeat (3) @(negedge clk);
    chk(cal_valid == 0, "R9 range change clears valid", cal_valid, 0);

    @(negedge clk);
    cal_sel = 2'b00; cal_req = 1'b1;
    repeat (4) @(negedge clk);
    cal_req = 1'b0;
    begin
      int k = 0;
      while (k < LS) begin
        @(negedge clk);
        if (cal_busy) k++;
      end
      bipolar = ~bipolar;
    end
    repeat (4) @(negedge clk);
    chk(cal_busy == 0 && cal_valid == 0, "R9 range change wins over completion", cal_valid, 0);
    chk(last_run == LS, "R4 self length again", last_run, LS);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule